// File: doc/BRIEF.md
# Mode-Selectable Local-Oscillator Divider

This block divides the local-oscillator signal of a frequency synthesizer down to the comparison rate. It does not handle the phase detector or the loop itself. Two oscillator inputs enter as single-cycle tick strobes in the block's own clock domain: a high-band tick and a low-band tick. A load strobe captures three things together: a divisor word, a band-select bit and a sense bit. The block then emits one pulse, one clock wide, for every completed division cycle.

The two mode bits pick one of three paths:

- **Prescaled** (band = 1): high-band ticks pass through a toggle prescaler into a 16-bit counter. The overall ratio is twice the programmed divisor.
- **Wide direct** (band = 0, sense = 1): low-band ticks drive the 16-bit counter directly.
- **Narrow direct** (band = 0, sense = 0): low-band ticks drive a separate 12-bit counter.

A divisor outside the legal range of its path is clamped to the nearer bound, and an error flag reports the clamp. A newly loaded setting waits for the current division cycle to end, so no period is ever cut short or stretched.

Top module: `lodiv_top`

## Requirements
- R1: With band-select 1, only high-band ticks are counted, the sense bit is ignored, and the number of high-band ticks per output pulse equals twice the (clamped) divisor.
- R2: With band-select 0 and sense 1, only low-band ticks are counted, and the number of low-band ticks per output pulse equals the (clamped) divisor.
- R3: With band-select 0 and sense 0, only low-band ticks are counted by the 12-bit divider, and the number of ticks per output pulse equals the (clamped) divisor.
- R4: In both 16-bit paths the divisor in use lies between 272 and 65535; a loaded word below 272 runs as 272.
- R5: In the 12-bit path the divisor in use lies between 4 and 4095; a word below 4 runs as 4, and a word above 4095 runs as 4095.
- R6: `range_err` is 0 after reset. From the cycle after each load it shows whether the loaded word lay outside the legal range of the path chosen by that same load. It holds that value until the next load.
- R7: A load made while dividing takes effect only at the next terminal count. The period in progress completes with the old divisor and path.
- R8: `div_out` is high for exactly one clock. It rises in the cycle after the tick that completes a division cycle, and there is one pulse per completed cycle.
- R9: After reset `div_out` stays low until a divisor is loaded. The first load takes effect one clock after the load cycle, and counting starts with the tick presented in the second cycle after the load.
- R10: Path and divisor are captured from the same load. The unselected oscillator input never influences the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; tick inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hi_tick | input | 1 | High-band oscillator event strobe |
| lo_tick | input | 1 | Low-band oscillator event strobe |
| load | input | 1 | Captures divisor and mode bits on this cycle |
| load_band | input | 1 | Band select: 1 picks the prescaled high-band path |
| load_sense | input | 1 | With band 0: 1 picks the wide direct path, 0 the 12-bit path |
| load_div | input | 16 | Programmed divisor word |
| div_out | output | 1 | One-clock pulse per completed division cycle |
| range_err | output | 1 | Last loaded word was clamped |

## Verification
A wrong count state or a stale shadow setting shows at `div_out` as a period of the wrong length, and it appears at the very next pulse. The bench therefore counts selected-input ticks between every pair of pulses. It compares each count with the ratio it derives arithmetically from the clamped word and the mode bits. A prescaler phase error, or a counter that also hears the unselected input, shows as a period off by one tick or more within a single division cycle. A clamp or flag error shows in the cycle right after the load.

// File: rtl/lodiv_pkg.sv
package lodiv_pkg;

  typedef enum logic [1:0] {
    PATH_PRE = 2'd0,
    PATH_D16 = 2'd1,
    PATH_D12 = 2'd2
  } path_e;

  function automatic path_e pick_path(input logic band, input logic sense);
    if (band) begin
      return PATH_PRE;
    end else if (sense) begin
      return PATH_D16;
    end else begin
      return PATH_D12;
    end
  endfunction

endpackage

// File: rtl/lodiv_rst_sync.sv
module lodiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/lodiv_limit.sv
module lodiv_limit
  import lodiv_pkg::*;
#(
  parameter int WIDE       = 16,
  parameter int NARROW     = 12,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  path_e             path,
  input  logic [WIDE-1:0]   raw,
  output logic [WIDE-1:0]   legal,
  output logic              clamped
);

  localparam int WIDE_MAX   = (1 << WIDE) - 1;
  localparam int NARROW_MAX = (1 << NARROW) - 1;

  logic [WIDE-1:0] lo_bound;
  logic [WIDE-1:0] hi_bound;

  always_comb begin
    if (path == PATH_D12) begin
      lo_bound = WIDE'(NARROW_MIN);
      hi_bound = WIDE'(NARROW_MAX);
    end else begin
      lo_bound = WIDE'(WIDE_MIN);
      hi_bound = WIDE'(WIDE_MAX);
    end
  end

  always_comb begin
    legal   = raw;
    clamped = 1'b0;
    if (raw < lo_bound) begin
      legal   = lo_bound;
      clamped = 1'b1;
    end else if (raw > hi_bound) begin
      legal   = hi_bound;
      clamped = 1'b1;
    end
  end

endmodule

// File: rtl/lodiv_count.sv
module lodiv_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         term
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign term = step && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = term ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);

endmodule

// File: rtl/lodiv_core.sv
module lodiv_core
  import lodiv_pkg::*;
#(
  parameter int WIDE       = 16,
  parameter int NARROW     = 12,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_tick,
  input  logic            lo_tick,
  input  logic            load,
  input  path_e           new_path,
  input  logic [WIDE-1:0] new_div,
  input  logic            new_err,
  output logic            div_pulse,
  output logic            range_err
);

  localparam int NARROW_MAX = (1 << NARROW) - 1;

  // shadow (pending) setting
  logic            pend_v_q, pend_v_d;
  path_e           pend_path_q, pend_path_d;
  logic [WIDE-1:0] pend_div_q, pend_div_d;
  // active setting
  logic            act_v_q, act_v_d;
  path_e           act_path_q, act_path_d;
  logic [WIDE-1:0] act_div_q, act_div_d;
  // prescaler, output, flag
  logic            pre_q, pre_d;
  logic            pulse_q, pulse_d;
  logic            err_q, err_d;

  logic              step_wide, step_narrow;
  logic              term_wide, term_narrow, term_any;
  logic              apply;
  logic              pre_en;
  logic [WIDE-1:0]   last_wide;
  logic [NARROW-1:0] last_narrow;

  assign pre_en      = act_v_q && (act_path_q == PATH_PRE) && hi_tick;
  assign step_wide   = act_v_q && (((act_path_q == PATH_PRE) && hi_tick && pre_q) ||
                                   ((act_path_q == PATH_D16) && lo_tick));
  assign step_narrow = act_v_q && (act_path_q == PATH_D12) && lo_tick;
  assign last_wide   = act_div_q - 1'b1;
  assign last_narrow = act_div_q[NARROW-1:0] - 1'b1;

  lodiv_count #(.W(WIDE)) u_cnt_wide (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (apply),
    .step (step_wide),
    .last (last_wide),
    .term (term_wide)
  );

  lodiv_count #(.W(NARROW)) u_cnt_narrow (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (apply),
    .step (step_narrow),
    .last (last_narrow),
    .term (term_narrow)
  );

  assign term_any = term_wide || term_narrow;
  assign apply    = pend_v_q && (term_any || !act_v_q);

  always_comb begin
    pend_v_d    = pend_v_q && !apply;
    pend_path_d = pend_path_q;
    pend_div_d  = pend_div_q;
    if (load) begin
      pend_v_d    = 1'b1;
      pend_path_d = new_path;
      pend_div_d  = new_div;
    end

    act_v_d    = act_v_q;
    act_path_d = act_path_q;
    act_div_d  = act_div_q;
    if (apply) begin
      act_v_d    = 1'b1;
      act_path_d = pend_path_q;
      act_div_d  = pend_div_q;
    end

    pre_d = pre_q;
    if (apply) begin
      pre_d = 1'b0;
    end else if (pre_en) begin
      pre_d = !pre_q;
    end

    pulse_d = term_any;
    err_d   = load ? new_err : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q    <= 1'b0;
      pend_path_q <= PATH_PRE;
      pend_div_q  <= '0;
      act_v_q     <= 1'b0;
      act_path_q  <= PATH_PRE;
      act_div_q   <= '0;
      pre_q       <= 1'b0;
      pulse_q     <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      pend_v_q    <= pend_v_d;
      pend_path_q <= pend_path_d;
      pend_div_q  <= pend_div_d;
      act_v_q     <= act_v_d;
      act_path_q  <= act_path_d;
      act_div_q   <= act_div_d;
      pre_q       <= pre_d;
      pulse_q     <= pulse_d;
      err_q       <= err_d;
    end
  end

  assign div_pulse = pulse_q;
  assign range_err = err_q;

  // R8
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_v_q |=> !div_pulse);

  // R7
  hold_setting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v_q && !term_any) |=> ($stable(act_div_q) && $stable(act_path_q)));

  // R4
  wide_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v_q && act_path_q != PATH_D12) |-> (act_div_q >= WIDE'(WIDE_MIN)));

  // R5
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_v_q && act_path_q == PATH_D12) |->
      (act_div_q >= WIDE'(NARROW_MIN) && act_div_q <= WIDE'(NARROW_MAX)));

  // R1
  pre_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_wide && act_path_q == PATH_PRE) |=> !pre_q);

endmodule

// File: rtl/lodiv_top.sv
module lodiv_top
  import lodiv_pkg::*;
#(
  parameter int WIDE       = 16,
  parameter int NARROW     = 12,
  parameter int WIDE_MIN   = 272,
  parameter int NARROW_MIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_tick,
  input  logic            lo_tick,
  input  logic            load,
  input  logic            load_band,
  input  logic            load_sense,
  input  logic [WIDE-1:0] load_div,
  output logic            div_out,
  output logic            range_err
);

  logic            srst_n;
  path_e           sel_path;
  logic [WIDE-1:0] legal_div;
  logic            clamped;

  lodiv_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(srst_n)
  );

  assign sel_path = pick_path(load_band, load_sense);

  lodiv_limit #(
    .WIDE      (WIDE),
    .NARROW    (NARROW),
    .WIDE_MIN  (WIDE_MIN),
    .NARROW_MIN(NARROW_MIN)
  ) u_limit (
    .path   (sel_path),
    .raw    (load_div),
    .legal  (legal_div),
    .clamped(clamped)
  );

  lodiv_core #(
    .WIDE      (WIDE),
    .NARROW    (NARROW),
    .WIDE_MIN  (WIDE_MIN),
    .NARROW_MIN(NARROW_MIN)
  ) u_core (
    .clk      (clk),
    .rst_n    (srst_n),
    .hi_tick  (hi_tick),
    .lo_tick  (lo_tick),
    .load     (load),
    .new_path (sel_path),
    .new_div  (legal_div),
    .new_err  (clamped),
    .div_pulse(div_out),
    .range_err(range_err)
  );

endmodule

// File: tb/tb_lodiv_top.sv
module tb_lodiv_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        hi_tick, lo_tick, load, load_band, load_sense;
  logic [15:0] load_div;
  logic        div_out, range_err;

  lodiv_top dut (
    .clk(clk), .rst_n(rst_n), .hi_tick(hi_tick), .lo_tick(lo_tick),
    .load(load), .load_band(load_band), .load_sense(load_sense),
    .load_div(load_div), .div_out(div_out), .range_err(range_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, pulses = 0, ticks = 0;
  bit timed_out = 0;
  // model state: mode 0 prescaled, 1 wide direct, 2 narrow direct
  bit active = 0, pend_v = 0, prev_out = 0;
  int cur_mode, cur_ratio, pend_mode, pend_ratio;
  bit cur_clamp, pend_clamp;
  bit drv_load = 0, drv_err;
  int drv_mode, drv_ratio;
  bit prev_hi = 0, prev_lo = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mode_of(input bit band, input bit sense);
    if (band) return 0;
    return sense ? 1 : 2;
  endfunction

  function automatic int clamp_of(input int mode, input int d);
    int lo = (mode == 2) ? 4 : 272;
    int hi = (mode == 2) ? 4095 : 65535;
    if (d < lo) return lo;
    if (d > hi) return hi;
    return d;
  endfunction

  task automatic cyc(input bit ld, input bit band, input bit sense, input int d);
    string tag;
    @(negedge clk);
    cycles++;
    if (cycles > WATCHDOG) timed_out = 1;
    if (active && ((cur_mode == 0) ? prev_hi : prev_lo)) ticks++;
    if (div_out) begin
      chk(!prev_out, "R8 single-width pulse", 1, 0);
      chk(active, "R9 no pulse before load", 0, 1);
      if (active) begin
        if (pend_v) tag = "R7 old setting completes";
        else if (cur_clamp) tag = (cur_mode == 2) ? "R5 clamp" : "R4 clamp";
        else if (cur_mode == 0) tag = "R1 prescaled ratio";
        else if (cur_mode == 1) tag = "R2 wide ratio";
        else tag = "R3 narrow ratio";
        chk(ticks == cur_ratio, tag, ticks, cur_ratio);
      end
      pulses++;
      ticks = 0;
      if (pend_v) begin
        cur_mode = pend_mode; cur_ratio = pend_ratio; cur_clamp = pend_clamp; pend_v = 0;
      end
    end
    prev_out = div_out;
    if (!active && pend_v) begin
      active = 1; cur_mode = pend_mode; cur_ratio = pend_ratio;
      cur_clamp = pend_clamp; pend_v = 0; ticks = 0;
    end
    if (drv_load) begin
      pend_v = 1; pend_mode = drv_mode; pend_ratio = drv_ratio; pend_clamp = drv_err;
      chk(range_err == drv_err, "R6 R10 range flag", range_err, drv_err);
    end
    drv_load   = ld;
    load       = ld;
    load_band  = band;
    load_sense = sense;
    load_div   = 16'(d);
    if (ld) begin
      drv_mode  = mode_of(band, sense);
      drv_ratio = clamp_of(drv_mode, d) * ((drv_mode == 0) ? 2 : 1);
      drv_err   = (clamp_of(drv_mode, d) != d);
    end
    hi_tick = ($urandom_range(0, 3) != 0);
    lo_tick = ($urandom_range(0, 3) != 0);
    prev_hi = hi_tick;
    prev_lo = lo_tick;
  endtask

  task automatic run(input bit band, input bit sense, input int d, input int nper);
    int target;
    cyc(1'b1, band, sense, d);
    target = pulses + nper + 1;
    while (pulses < target && !timed_out) cyc(1'b0, 1'b0, 1'b0, 0);
  endtask

  initial begin
    rst_n = 1'b0; hi_tick = 0; lo_tick = 0; load = 0;
    load_band = 0; load_sense = 0; load_div = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 0);
      chk(div_out == 1'b0, "R9 idle output low", div_out, 0);
      chk(range_err == 1'b0, "R6 flag clear after reset", range_err, 0);
    end
    // narrow path near-exhaustive sweep incl. clamps below 4
    for (int d = 0; d <= 40; d++) run(1'b0, 1'b0, d, 2);
    run(1'b0, 1'b0, 4095, 1);
    run(1'b0, 1'b0, 5000, 1);   // R5 clamp above 4095
    // wide direct path across the lower bound
    for (int d = 266; d <= 280; d++) run(1'b0, 1'b1, d, 2);
    run(1'b0, 1'b1, 0, 1);      // R4 clamp
    // prescaled path, sense bit toggled to show it is ignored (R1)
    for (int d = 268; d <= 276; d++) run(1'b1, d[0], d, 2);
    // quick path changes back and forth (R10)
    run(1'b0, 1'b0, 7, 2);
    run(1'b1, 1'b0, 272, 1);
    run(1'b0, 1'b0, 9, 2);
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule